// File: doc/BRIEF.md
# Two-Level Write-to-Clear Interrupt Controller

This block collects transmit, receive, beacon and error event pulses into sticky status bits on two levels. Five secondary status registers hold per-queue and per-cause bits. A single primary status register has two kinds of bits. Two of them are direct latches, for frame received and beacon not ready. The other ten are live ORs of groups of secondary bits. Any bit of any status register is cleared by writing a one to its position.

A primary mask, a per-queue underrun mask and a global enable decide whether the single interrupt line is driven. Register access is a single-cycle port: a write is taken on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. Address map: 0 primary status, 1 to 5 secondary 0 to 4, 6 primary mask, 7 underrun mask, 8 global enable.

Top module: `irqc_top`

## Requirements
- R1: After reset every status register, both masks and the global enable read as zero, and `irq` is low.
- R2: An event pulse sets its secondary bit on the next clock edge, and the bit stays set until it is cleared by a write.
- R3: A write to a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: An event arriving on the same edge as a write that clears its bit leaves the bit set.
- R5: Secondary 0 holds transmit-ok at [NQ-1:0] and transmit-descriptor at [2NQ-1:NQ], which drive primary bits 2 and 3. Secondary 1 holds transmit-error at [NQ-1:0] and end-of-list at [2NQ-1:NQ], which drive primary bits 4 and 5. Each primary bit is the OR of its field.
- R6: Primary bit 6 (underrun) is the OR of the secondary 2 underrun field [NQ-1:0], ANDed bit by bit with the underrun mask at address 7.
- R7: Primary bit 7 (host error) is the OR of secondary 2 bits NQ (bus abort), NQ+1 (system error) and NQ+2 (parity). Primary bit 8 (beacon misc) is the OR of secondary 2 bits NQ+3 to NQ+5.
- R8: Secondary 3 holds constant-rate overrun at [NQ-1:0], which drives primary bit 9, and underrun at [2NQ-1:NQ], which drives primary bit 10. Secondary 4 holds queue trigger at [NQ-1:0], which drives primary bit 11.
- R9: Primary bit 0 (receive ok) and bit 1 (beacon not ready) are direct latches. Writing all ones to the primary register clears them. Such a write leaves the aggregated primary bits and all secondary bits unchanged.
- R10: `irq` is high only when the global enable (address 8, bit 0) is set and at least one primary bit is set whose primary mask bit (address 6) is also set.
- R11: Both mask registers and the global enable read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| ev_rxok | input | 1 | Frame-received event pulse |
| ev_bnr | input | 1 | Beacon-not-ready event pulse |
| ev_sec0 | input | 2*NQ | Transmit-ok / descriptor events per queue |
| ev_sec1 | input | 2*NQ | Transmit-error / end-of-list events per queue |
| ev_sec2 | input | NQ+6 | Underrun per queue, bus errors, beacon causes |
| ev_sec3 | input | 2*NQ | Constant-rate overrun / underrun per queue |
| ev_sec4 | input | NQ | Queue-trigger events per queue |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that event inputs and `reg_wr` change only between clock edges. They also assume that `reg_wdata` and `reg_addr` are stable while `reg_wr` is high. The bench meets this by driving every input on the falling edge and holding it for a full cycle. Events are pulses one cycle long. Writes and events that must coincide are raised together on the same falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NPRIM = 12;
  localparam int NSEC  = 5;

  localparam logic [3:0] A_PRIM  = 4'd0;
  localparam logic [3:0] A_SEC0  = 4'd1;
  localparam logic [3:0] A_PMASK = 4'd6;
  localparam logic [3:0] A_UMASK = 4'd7;
  localparam logic [3:0] A_GIE   = 4'd8;

  localparam int P_RXOK    = 0;
  localparam int P_BNR     = 1;
  localparam int P_TXOK    = 2;
  localparam int P_TXDESC  = 3;
  localparam int P_TXERR   = 4;
  localparam int P_EOL     = 5;
  localparam int P_URN     = 6;
  localparam int P_HOSTERR = 7;
  localparam int P_BCNMISC = 8;
  localparam int P_CBROVR  = 9;
  localparam int P_CBRUND  = 10;
  localparam int P_QTRIG   = 11;
endpackage

// File: rtl/irqc_wtc_bank.sv
module irqc_wtc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr_en | (|set);
    q_d  = (q & ~(clr_en ? clr_bits : '0)) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/irqc_agg.sv
module irqc_agg
  import irqc_pkg::*;
#(
  parameter int NQ = 4
) (
  input  logic [2*NQ-1:0]  s0,
  input  logic [2*NQ-1:0]  s1,
  input  logic [NQ+5:0]    s2,
  input  logic [2*NQ-1:0]  s3,
  input  logic [NQ-1:0]    s4,
  input  logic [NQ-1:0]    umask,
  input  logic [1:0]       pdir,
  output logic [NPRIM-1:0] prim
);
  always_comb begin
    prim            = '0;
    prim[P_RXOK]    = pdir[0];
    prim[P_BNR]     = pdir[1];
    prim[P_TXOK]    = |s0[NQ-1:0];
    prim[P_TXDESC]  = |s0[2*NQ-1:NQ];
    prim[P_TXERR]   = |s1[NQ-1:0];
    prim[P_EOL]     = |s1[2*NQ-1:NQ];
    prim[P_URN]     = |(s2[NQ-1:0] & umask);
    prim[P_HOSTERR] = |s2[NQ+2:NQ];
    prim[P_BCNMISC] = |s2[NQ+5:NQ+3];
    prim[P_CBROVR]  = |s3[NQ-1:0];
    prim[P_CBRUND]  = |s3[2*NQ-1:NQ];
    prim[P_QTRIG]   = |s4;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NQ = 4,
  parameter int DW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ev_rxok,
  input  logic            ev_bnr,
  input  logic [2*NQ-1:0] ev_sec0,
  input  logic [2*NQ-1:0] ev_sec1,
  input  logic [NQ+5:0]   ev_sec2,
  input  logic [2*NQ-1:0] ev_sec3,
  input  logic [NQ-1:0]   ev_sec4,
  output logic            irq
);
  localparam int SW = (2*NQ > NQ+6) ? 2*NQ : NQ+6;

  logic [SW-1:0]    sec_set [NSEC];
  logic [SW-1:0]    sec_q   [NSEC];
  logic [1:0]       pdir_q;
  logic [NPRIM-1:0] prim_view;
  logic [NPRIM-1:0] pmask_q, pmask_d;
  logic [NQ-1:0]    umask_q, umask_d;
  logic             gie_q, gie_d;
  logic             pmask_en, umask_en, gie_en, prim_clr;

  always_comb begin
    for (int k = 0; k < NSEC; k++) sec_set[k] = '0;
    sec_set[0][2*NQ-1:0] = ev_sec0;
    sec_set[1][2*NQ-1:0] = ev_sec1;
    sec_set[2][NQ+5:0]   = ev_sec2;
    sec_set[3][2*NQ-1:0] = ev_sec3;
    sec_set[4][NQ-1:0]   = ev_sec4;
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    logic clr_en;
    assign clr_en = reg_wr && (reg_addr == A_SEC0 + 4'(k));
    irqc_wtc_bank #(.W(SW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (sec_set[k]),
      .clr_en   (clr_en),
      .clr_bits (reg_wdata[SW-1:0]),
      .q        (sec_q[k])
    );
  end

  assign prim_clr = reg_wr && (reg_addr == A_PRIM);

  irqc_wtc_bank #(.W(2)) u_pdir (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      ({ev_bnr, ev_rxok}),
    .clr_en   (prim_clr),
    .clr_bits (reg_wdata[1:0]),
    .q        (pdir_q)
  );

  irqc_agg #(.NQ(NQ)) u_agg (
    .s0    (sec_q[0][2*NQ-1:0]),
    .s1    (sec_q[1][2*NQ-1:0]),
    .s2    (sec_q[2][NQ+5:0]),
    .s3    (sec_q[3][2*NQ-1:0]),
    .s4    (sec_q[4][NQ-1:0]),
    .umask (umask_q),
    .pdir  (pdir_q),
    .prim  (prim_view)
  );

  always_comb begin
    pmask_en = reg_wr && (reg_addr == A_PMASK);
    umask_en = reg_wr && (reg_addr == A_UMASK);
    gie_en   = reg_wr && (reg_addr == A_GIE);
    pmask_d  = reg_wdata[NPRIM-1:0];
    umask_d  = reg_wdata[NQ-1:0];
    gie_d    = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= '0;
      umask_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      if (pmask_en) pmask_q <= pmask_d;
      if (umask_en) umask_q <= umask_d;
      if (gie_en)   gie_q   <= gie_d;
    end
  end

  assign irq = gie_q & (|(prim_view & pmask_q));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PRIM:  reg_rdata[NPRIM-1:0] = prim_view;
      A_PMASK: reg_rdata[NPRIM-1:0] = pmask_q;
      A_UMASK: reg_rdata[NQ-1:0]    = umask_q;
      A_GIE:   reg_rdata[0]         = gie_q;
      default: begin
        for (int k = 0; k < NSEC; k++)
          if (reg_addr == A_SEC0 + 4'(k)) reg_rdata[SW-1:0] = sec_q[k];
      end
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NQ = 4,
  parameter int DW = 12,
  parameter int SW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [3:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            ev_rxok,
  input logic            ev_bnr,
  input logic [2*NQ-1:0] ev_sec0,
  input logic            irq,
  input logic            gie_q,
  input logic [SW-1:0]   sec0_q,
  input logic [1:0]      pdir_q
);
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq); // R10

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_sec0) |=> ((sec0_q[2*NQ-1:0] & $past(ev_sec0)) == $past(ev_sec0))); // R4

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_SEC0)
      |=> ((sec0_q & $past(sec0_q)) == $past(sec0_q))); // R2

  AST_PRIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PRIM)
      |=> ((pdir_q & $past(reg_wdata[1:0]) & ~$past({ev_bnr, ev_rxok})) == 2'b00)); // R9
endmodule

bind irqc_top irqc_chk #(.NQ(NQ), .DW(DW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ev_rxok   (ev_rxok),
  .ev_bnr    (ev_bnr),
  .ev_sec0   (ev_sec0),
  .irq       (irq),
  .gie_q     (gie_q),
  .sec0_q    (sec_q[0]),
  .pdir_q    (pdir_q)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int NQ = 4;
  localparam int DW = 12;

  logic            clk;
  logic            rst_n;
  logic            reg_wr;
  logic [3:0]      reg_addr;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;
  logic            ev_rxok, ev_bnr;
  logic [2*NQ-1:0] ev_sec0, ev_sec1, ev_sec3;
  logic [NQ+5:0]   ev_sec2;
  logic [NQ-1:0]   ev_sec4;
  logic            irq;
  int              n_run, n_fail;

  irqc_top #(.NQ(NQ), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rxok(ev_rxok),
    .ev_bnr(ev_bnr), .ev_sec0(ev_sec0), .ev_sec1(ev_sec1), .ev_sec2(ev_sec2),
    .ev_sec3(ev_sec3), .ev_sec4(ev_sec4), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle_inputs();
    ev_rxok = 0; ev_bnr = 0; ev_sec0 = '0; ev_sec1 = '0;
    ev_sec2 = '0; ev_sec3 = '0; ev_sec4 = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 9; a++) rd("R1 reset read", 4'(a), '0);
    chk("R1 reset irq", 32'(irq), 0);
  endtask

  task automatic t_sticky_sec0();
    @(negedge clk); ev_sec0 = 8'h21;
    @(negedge clk); ev_sec0 = '0;
    repeat (3) @(negedge clk);
    rd("R2 sec0 sticky", 4'd1, 12'h021);
    rd("R5 txok+txdesc primary", 4'd0, 12'h00C);
    wr(4'd1, 12'h001);
    rd("R3 partial clear sec0", 4'd1, 12'h020);
    rd("R5 txok dropped", 4'd0, 12'h008);
    wr(4'd1, 12'h020);
    rd("R3 full clear sec0", 4'd1, 12'h000);
  endtask

  task automatic t_sec1();
    @(negedge clk); ev_sec1 = 8'h80;
    @(negedge clk); ev_sec1 = '0;
    rd("R5 eol primary", 4'd0, 12'h020);
    @(negedge clk); ev_sec1 = 8'h02;
    @(negedge clk); ev_sec1 = '0;
    rd("R5 txerr+eol primary", 4'd0, 12'h030);
    wr(4'd2, 12'hFFF);
    rd("R3 sec1 cleared", 4'd2, 12'h000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); ev_sec0 = 8'h04;
    @(negedge clk); ev_sec0 = '0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 12'h00C; ev_sec0 = 8'h08;
    @(negedge clk);
    reg_wr = 1'b0; ev_sec0 = '0;
    rd("R4 event kept over clear", 4'd1, 12'h008);
    wr(4'd1, 12'h008);
    rd("R3 sec0 empty", 4'd1, 12'h000);
  endtask

  task automatic t_underrun_mask();
    @(negedge clk); ev_sec2 = 10'h002;
    @(negedge clk); ev_sec2 = '0;
    rd("R2 sec2 underrun latched", 4'd3, 12'h002);
    rd("R6 masked underrun", 4'd0, 12'h000);
    wr(4'd7, 12'h002);
    rd("R11 umask readback", 4'd7, 12'h002);
    rd("R6 unmasked underrun", 4'd0, 12'h040);
    wr(4'd7, 12'h001);
    rd("R6 other queue masked", 4'd0, 12'h000);
    wr(4'd3, 12'h3FF);
  endtask

  task automatic t_host_beacon();
    @(negedge clk); ev_sec2 = 10'h020;
    @(negedge clk); ev_sec2 = '0;
    rd("R7 host error", 4'd0, 12'h080);
    @(negedge clk); ev_sec2 = 10'h100;
    @(negedge clk); ev_sec2 = '0;
    rd("R7 beacon misc", 4'd0, 12'h180);
    wr(4'd3, 12'h020);
    rd("R7 host error cleared", 4'd0, 12'h100);
    wr(4'd3, 12'h3FF);
  endtask

  task automatic t_cbr_trig();
    @(negedge clk); ev_sec3 = 8'h10;
    @(negedge clk); ev_sec3 = '0;
    rd("R8 cbr underrun", 4'd0, 12'h400);
    @(negedge clk); ev_sec3 = 8'h01; ev_sec4 = 4'h8;
    @(negedge clk); ev_sec3 = '0; ev_sec4 = '0;
    rd("R8 cbr overrun and trigger", 4'd0, 12'hE00);
    rd("R8 sec4 read", 4'd5, 12'h008);
    wr(4'd4, 12'hFFF);
    wr(4'd5, 12'hFFF);
    rd("R8 all cleared", 4'd0, 12'h000);
  endtask

  task automatic t_primary_write();
    @(negedge clk); ev_rxok = 1; ev_bnr = 1; ev_sec0 = 8'h01;
    @(negedge clk); ev_rxok = 0; ev_bnr = 0; ev_sec0 = '0;
    rd("R9 direct and aggregated set", 4'd0, 12'h007);
    wr(4'd0, 12'hFFF);
    rd("R9 only direct cleared", 4'd0, 12'h004);
    rd("R9 secondary untouched", 4'd1, 12'h001);
    wr(4'd1, 12'h001);
    rd("R9 aggregated clears via secondary", 4'd0, 12'h000);
  endtask

  task automatic t_irq();
    wr(4'd6, 12'h001);
    rd("R11 pmask readback", 4'd6, 12'h001);
    @(negedge clk); ev_rxok = 1;
    @(negedge clk); ev_rxok = 0;
    chk("R10 irq off without enable", 32'(irq), 0);
    wr(4'd8, 12'h001);
    rd("R11 gie readback", 4'd8, 12'h001);
    chk("R10 irq on", 32'(irq), 1);
    wr(4'd6, 12'h000);
    chk("R10 irq masked", 32'(irq), 0);
    wr(4'd6, 12'h004);
    @(negedge clk); ev_sec0 = 8'h02;
    @(negedge clk); ev_sec0 = '0;
    chk("R10 irq from aggregated bit", 32'(irq), 1);
    wr(4'd1, 12'h002);
    chk("R10 irq drops after clear", 32'(irq), 0);
    wr(4'd0, 12'h001);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset();
        t_sticky_sec0();
        t_sec1();
        t_same_cycle();
        t_underrun_mask();
        t_host_beacon();
        t_cbr_trig();
        t_primary_write();
        t_irq();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule